// File: doc/BRIEF.md
# Bi-Endian Load/Store Data Unit

This unit sits between a 32-bit register datapath and a byte-addressed memory port. It accepts one byte, halfword or word load or store at a time. It turns a store into a word-aligned memory request that carries the data lanes and the byte enables. It turns the returned read word into a 32-bit register value, with sign or zero extension. A mode input picks little-endian or big-endian byte ordering for each access. The unit captures that mode when it accepts the access, so the input can change while the access is still in flight.

Before any request goes out, the unit checks the access against two rules. The first is alignment. The second is a set of permissions for each address region. The top address bits select a region. Each region can be read-only, word-only, or both, as set by parameter masks. An access that breaks a rule never reaches memory, and it is answered with a fault code. A load that targets register index zero still goes through the full memory access and can still fault. Only its write-back strobe is held low.

Top module: `lsu_endian`

## Requirements
- R1: Size code 1 (halfword) at an odd address, size code 2 (word) with address bits [1:0] not zero, and size code 3 (reserved) all answer with fault code 1 (misaligned). No memory request is issued for them. Misaligned takes priority over an access fault.
- R2: With the default masks, the region is selected by address bits [31:30]. A store to region 1 (read-only) answers with fault code 2. A byte or halfword access to region 2 (word-only) also answers with fault code 2. In both cases no memory request is issued and no memory byte changes. A faulted response has the write-back strobe low and data zero.
- R3: In little-endian mode (mode input 0), a store of n bytes at address A places register byte i (i=0 least significant) at byte address A+i. Memory lane k holds byte address (A with bits [1:0] cleared)+k, and only the written lanes are enabled.
- R4: In big-endian mode (mode input 1), a store of n bytes at address A places register byte i at byte address A+n-1-i. The most significant register byte goes to the lowest address.
- R5: A byte stored at an address reads back unchanged from a byte load at that address, whatever mode is used for either access.
- R6: In little-endian mode, a load of n bytes at address A fills register byte i from byte address A+i.
- R7: In big-endian mode, a load of n bytes at address A fills register byte i from byte address A+n-1-i.
- R8: A load with the unsigned input low sign-extends the selected bytes to 32 bits. With the unsigned input high it zero-extends them.
- R9: A load whose destination index is 0 still issues exactly one memory request and still reports faults. Its write-back strobe stays low.
- R10: The memory request is held stable until it is accepted. A fault response appears one cycle after the access is accepted. A store response appears one cycle after the memory accepts the request. A load response appears one cycle after the read data arrives. Each response lasts exactly one cycle.
- R11: The mode input is sampled when the access is accepted. Changing it while the access is in flight has no effect on that access.
- R12: After reset the unit is ready for a request, and it has no memory request and no response pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_endian_i | input | 1 | Byte order for the access being accepted: 0 little-endian, 1 big-endian |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Unit idle and able to accept a request |
| req_store_i | input | 1 | 1 store, 0 load |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_unsigned_i | input | 1 | Zero-extend the load result |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Store data, right-justified in register order |
| req_rd_i | input | 5 | Destination register index |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_be_o | output | 4 | Byte enables, lane k is byte address offset k |
| mem_wdata_o | output | 32 | Store data placed on its lanes |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data, lane k is byte address offset k |
| rsp_valid_o | output | 1 | Response valid for one cycle |
| rsp_fault_o | output | 2 | 0 none, 1 misaligned, 2 access fault |
| rsp_wb_o | output | 1 | Write rsp_data_o to rsp_rd_o |
| rsp_rd_o | output | 5 | Destination register index |
| rsp_data_o | output | 32 | Extended load value |

## Verification
A fault is answered one cycle after it is accepted. A store is answered one cycle after the memory takes the request, and a load one cycle after its read data arrives. A memory stall of s cycles therefore moves a store response to 2+s cycles and a load response to 3+s cycles after the request is driven, while a fault stays at 1. Each scoreboard entry carries this latency, and the monitor checks it at the falling edge at which the response appears. A count of memory grants confirms that faulted accesses issue nothing and that loads to index zero issue exactly one request.

// File: rtl/lsu_endian_pkg.sv
package lsu_endian_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ALIGN  = 2'd1,
    FLT_ACCESS = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } state_e;

  function automatic int access_bytes(logic [1:0] sz, int nb);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return nb;
    endcase
  endfunction
endpackage

// File: rtl/lsu_endian_check.sv
module lsu_endian_check
  import lsu_endian_pkg::*;
#(
  parameter int                     NUM_REGIONS = 4,
  parameter int                     OFF_W       = 2,
  parameter logic [NUM_REGIONS-1:0] RO_MASK     = '0,
  parameter logic [NUM_REGIONS-1:0] WO_MASK     = '0,
  localparam int                    RB          = $clog2(NUM_REGIONS)
) (
  input  logic [RB-1:0]    region_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic             store_i,
  output fault_e           fault_o
);
  logic misaligned, denied;

  always_comb begin
    misaligned = 1'b0;
    case (size_i)
      SZ_HALF: misaligned = off_i[0];
      SZ_WORD: misaligned = (off_i != '0);
      SZ_BAD:  misaligned = 1'b1;
      default: misaligned = 1'b0;
    endcase
    denied = (store_i && RO_MASK[region_i]) ||
             (WO_MASK[region_i] && (size_i != SZ_WORD));
    if (misaligned)  fault_o = FLT_ALIGN;
    else if (denied) fault_o = FLT_ACCESS;
    else             fault_o = FLT_NONE;
  end
endmodule

// File: rtl/lsu_endian_store_fmt.sv
module lsu_endian_store_fmt
  import lsu_endian_pkg::*;
#(
  parameter int  NB    = 4,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [8*NB-1:0]  wdata_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic             big_i,
  output logic [8*NB-1:0]  lanes_o,
  output logic [NB-1:0]    be_o
);
  for (genvar k = 0; k < NB; k++) begin : g_lane
    localparam int K = k;
    always_comb begin : lane_map
      int n, j;
      logic [OFF_W-1:0] sig;
      n   = access_bytes(size_i, NB);
      j   = K - int'(off_i);
      sig = big_i ? OFF_W'(n - 1 - j) : OFF_W'(j);
      if (j >= 0 && j < n) begin
        be_o[k]          = 1'b1;
        lanes_o[8*k +: 8] = wdata_i[8*sig +: 8];
      end else begin
        be_o[k]          = 1'b0;
        lanes_o[8*k +: 8] = '0;
      end
    end
  end
endmodule

// File: rtl/lsu_endian_load_fmt.sv
module lsu_endian_load_fmt
  import lsu_endian_pkg::*;
#(
  parameter int  NB    = 4,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [8*NB-1:0]  rdata_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic             unsigned_i,
  input  logic             big_i,
  output logic [8*NB-1:0]  value_o
);
  logic [OFF_W-1:0] msb_lane;
  logic             fill_bit;
  int               nbytes;

  always_comb begin
    nbytes   = access_bytes(size_i, NB);
    // most significant selected byte sits at the lowest address when big-endian
    msb_lane = big_i ? off_i : OFF_W'(int'(off_i) + nbytes - 1);
    fill_bit = !unsigned_i && rdata_i[8*msb_lane + 7];
  end

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam int I = i;
    always_comb begin : byte_sel
      logic [OFF_W-1:0] src;
      src = big_i ? OFF_W'(int'(off_i) + nbytes - 1 - I) : OFF_W'(int'(off_i) + I);
      if (I < nbytes) value_o[8*i +: 8] = rdata_i[8*src +: 8];
      else            value_o[8*i +: 8] = {8{fill_bit}};
    end
  end
endmodule

// File: rtl/lsu_endian.sv
module lsu_endian
  import lsu_endian_pkg::*;
#(
  parameter int                     ADDR_W      = 32,
  parameter int                     DATA_W      = 32,
  parameter int                     RD_W        = 5,
  parameter int                     NUM_REGIONS = 4,
  parameter logic [NUM_REGIONS-1:0] RO_MASK     = 4'b0010,
  parameter logic [NUM_REGIONS-1:0] WO_MASK     = 4'b0100,
  localparam int                    NB          = DATA_W / 8,
  localparam int                    OFF_W       = $clog2(NB),
  localparam int                    RB          = $clog2(NUM_REGIONS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              big_endian_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_store_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_unsigned_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [RD_W-1:0]   req_rd_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [NB-1:0]     mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_fault_o,
  output logic              rsp_wb_o,
  output logic [RD_W-1:0]   rsp_rd_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  state_e            state_q;
  fault_e            chk_fault, fault_q;
  logic [DATA_W-1:0] st_lanes, ld_value, wdata_q, rdata_q;
  logic [NB-1:0]     st_be, be_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic [RD_W-1:0]   rd_q;
  logic              store_q, uns_q, big_q, wb_q;

  lsu_endian_check #(
    .NUM_REGIONS(NUM_REGIONS), .OFF_W(OFF_W), .RO_MASK(RO_MASK), .WO_MASK(WO_MASK)
  ) u_check (
    .region_i(req_addr_i[ADDR_W-1 -: RB]),
    .off_i   (req_addr_i[OFF_W-1:0]),
    .size_i  (req_size_i),
    .store_i (req_store_i),
    .fault_o (chk_fault)
  );

  lsu_endian_store_fmt #(.NB(NB)) u_store_fmt (
    .wdata_i(req_wdata_i),
    .off_i  (req_addr_i[OFF_W-1:0]),
    .size_i (req_size_i),
    .big_i  (big_endian_i),
    .lanes_o(st_lanes),
    .be_o   (st_be)
  );

  // mode and layout come from registers captured at accept
  lsu_endian_load_fmt #(.NB(NB)) u_load_fmt (
    .rdata_i   (mem_rdata_i),
    .off_i     (off_q),
    .size_i    (size_q),
    .unsigned_i(uns_q),
    .big_i     (big_q),
    .value_o   (ld_value)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fault_q <= FLT_NONE;
      wdata_q <= '0;
      rdata_q <= '0;
      be_q    <= '0;
      addr_q  <= '0;
      off_q   <= '0;
      size_q  <= '0;
      rd_q    <= '0;
      store_q <= 1'b0;
      uns_q   <= 1'b0;
      big_q   <= 1'b0;
      wb_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          store_q <= req_store_i;
          size_q  <= req_size_i;
          uns_q   <= req_unsigned_i;
          big_q   <= big_endian_i;
          off_q   <= req_addr_i[OFF_W-1:0];
          rd_q    <= req_rd_i;
          addr_q  <= {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
          wdata_q <= st_lanes;
          be_q    <= st_be;
          fault_q <= chk_fault;
          rdata_q <= '0;
          wb_q    <= 1'b0;
          state_q <= (chk_fault != FLT_NONE) ? ST_RESP : ST_ISSUE;
        end
        ST_ISSUE: if (mem_ready_i) begin
          state_q <= store_q ? ST_RESP : ST_WAIT;
        end
        ST_WAIT: if (mem_rvalid_i) begin
          rdata_q <= ld_value;
          wb_q    <= (rd_q != '0);
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_valid_o = (state_q == ST_ISSUE);
  assign mem_we_o    = store_q;
  assign mem_addr_o  = addr_q;
  assign mem_be_o    = be_q;
  assign mem_wdata_o = wdata_q;
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_fault_o = fault_q;
  assign rsp_wb_o    = wb_q;
  assign rsp_rd_o    = rd_q;
  assign rsp_data_o  = rdata_q;
endmodule

// File: rtl/lsu_endian_sva.sv
module lsu_endian_sva #(
  parameter int                     ADDR_W      = 32,
  parameter int                     DATA_W      = 32,
  parameter int                     RD_W        = 5,
  parameter int                     NUM_REGIONS = 4,
  parameter logic [NUM_REGIONS-1:0] RO_MASK     = 4'b0010,
  localparam int                    NB          = DATA_W / 8,
  localparam int                    RB          = $clog2(NUM_REGIONS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [NB-1:0]     mem_be_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              rsp_valid_o,
  input logic [1:0]        rsp_fault_o,
  input logic              rsp_wb_o,
  input logic [RD_W-1:0]   rsp_rd_o,
  input logic [DATA_W-1:0] rsp_data_o
);
  p_hold_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) &&
                                    $stable(mem_be_o) && $stable(mem_wdata_o) && $stable(mem_we_o));

  p_rsp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);

  p_rd0_no_wb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_rd_o == '0) |-> !rsp_wb_o);

  p_fault_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_fault_o != 2'd0) |-> !rsp_wb_o && (rsp_data_o == '0));

  p_no_ro_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_we_o |-> !RO_MASK[mem_addr_o[ADDR_W-1 -: RB]]);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_valid_o && !rsp_valid_o);

  p_be_shape_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> ($countones(mem_be_o) == 1) || ($countones(mem_be_o) == 2) ||
                    ($countones(mem_be_o) == NB));

  p_word_aligned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_addr_o[1:0] == 2'b00));
endmodule

bind lsu_endian lsu_endian_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_W(RD_W), .NUM_REGIONS(NUM_REGIONS), .RO_MASK(RO_MASK)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
  .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o), .rsp_wb_o(rsp_wb_o),
  .rsp_rd_o(rsp_rd_o), .rsp_data_o(rsp_data_o)
);

// File: tb/lsu_endian_bench.sv
module lsu_endian_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string       req;
    logic [1:0]  fault;
    logic        wb;
    logic [4:0]  rd;
    logic [31:0] data;
    int          lat;
    int          t0;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian;
  logic        req_valid, req_store, req_unsigned;
  logic        req_ready;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic [4:0]  req_rd;
  logic        mem_valid, mem_ready, mem_we, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        rsp_valid, rsp_wb;
  logic [1:0]  rsp_fault;
  logic [4:0]  rsp_rd;
  logic [31:0] rsp_data;

  logic [7:0]  phys    [256];
  logic [7:0]  ref_mem [256];
  item_t       sb_q [$];
  int          checks = 0, errors = 0, grants = 0, cyc = 0, stall = 0, wait_cnt = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lsu_endian u_lsu_endian (
    .clk_i(clk), .rst_ni(rst_n), .big_endian_i(big_endian),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_store_i(req_store),
    .req_size_i(req_size), .req_unsigned_i(req_unsigned), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_rd_i(req_rd),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_wb_o(rsp_wb),
    .rsp_rd_o(rsp_rd), .rsp_data_o(rsp_data)
  );

  assign mem_ready = mem_valid && (wait_cnt >= stall);

  // memory model: lane k is byte address base+k, read data one cycle after grant
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(posedge clk);
      mem_rvalid <= 1'b0;
      if (mem_valid && mem_ready) begin
        grants   <= grants + 1;
        wait_cnt <= 0;
        if (mem_we) begin
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) phys[{mem_addr[7:2], 2'(k)}] <= mem_wdata[8*k +: 8];
        end else begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= {phys[{mem_addr[7:2], 2'd3}], phys[{mem_addr[7:2], 2'd2}],
                         phys[{mem_addr[7:2], 2'd1}], phys[{mem_addr[7:2], 2'd0}]};
        end
      end else if (mem_valid) begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (sb_q.size() == 0) begin
          check("R10", "unexpected response", 32'd1, 32'd0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          check(it.req, "fault", 32'(rsp_fault), 32'(it.fault));
          check(it.req, "wb", 32'(rsp_wb), 32'(it.wb));
          check(it.req, "rd", 32'(rsp_rd), 32'(it.rd));
          check(it.req, "data", rsp_data, it.data);
          check("R10", {it.req, " latency"}, 32'(cyc - it.t0), 32'(it.lat));
        end
      end
    end
  end

  task automatic access(string req, bit st, logic [1:0] sz, bit uns, logic [31:0] addr,
                        logic [31:0] wd, logic [4:0] rd, bit big, bit flip = 1'b0);
    item_t it;
    int n;
    bit mis, acc;
    logic [31:0] val;
    n   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    mis = (sz == 2'd3) || (sz == 2'd1 && addr[0]) || (sz == 2'd2 && addr[1:0] != 2'b00);
    acc = (st && addr[31:30] == 2'd1) || (addr[31:30] == 2'd2 && sz != 2'd2);
    val = '0;
    it.req   = req;
    it.rd    = rd;
    it.fault = mis ? 2'd1 : acc ? 2'd2 : 2'd0;
    it.wb    = 1'b0;
    if (it.fault == 2'd0) begin
      for (int i = 0; i < n; i++) begin
        logic [7:0] a;
        a = addr[7:0] + 8'(big ? n - 1 - i : i);
        if (st) ref_mem[a] = wd[8*i +: 8];
        else    val[8*i +: 8] = ref_mem[a];
      end
      if (!st) begin
        if (!uns && val[8*n-1])
          for (int i = n; i < 4; i++) val[8*i +: 8] = 8'hFF;
        it.wb = (rd != 5'd0);
      end
      it.lat = st ? 2 + stall : 3 + stall;
    end else begin
      it.lat = 1;
    end
    it.data = st ? 32'd0 : val;
    while (!req_ready) @(negedge clk);
    it.t0 = cyc;
    sb_q.push_back(it);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
    req_addr = addr; req_wdata = wd; req_rd = rd; big_endian = big;
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = 32'hDEAD_BEEF;
    if (flip) big_endian = !big;
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int g0;
    for (int i = 0; i < 256; i++) begin phys[i] = 8'h00; ref_mem[i] = 8'h00; end
    req_valid = 0; req_store = 0; req_size = 0; req_unsigned = 0;
    req_addr = 0; req_wdata = 0; req_rd = 0; big_endian = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "ready", 32'(req_ready), 32'd1);
    check("R12", "mem_valid", 32'(mem_valid), 32'd0);
    check("R12", "rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 / R4 stores read back by byte
    access("R3", 1, 2'd2, 0, 32'h10, 32'h1122_3344, 5'd1, 0);
    for (int i = 0; i < 4; i++) access("R3", 0, 2'd0, 1, 32'h10 + i, 0, 5'd2, 0);
    access("R4", 1, 2'd2, 0, 32'h20, 32'hA1B2_C3D4, 5'd1, 1);
    for (int i = 0; i < 4; i++) access("R4", 0, 2'd0, 1, 32'h20 + i, 0, 5'd2, 0);
    access("R3", 1, 2'd1, 0, 32'h32, 32'h0000_BEEF, 5'd1, 0);
    access("R4", 1, 2'd1, 0, 32'h36, 32'h0000_CAFE, 5'd1, 1);
    access("R4", 0, 2'd2, 0, 32'h34, 0, 5'd3, 0);
    access("R3", 0, 2'd2, 0, 32'h30, 0, 5'd3, 0);

    // R6 / R7 loads
    access("R6", 0, 2'd2, 0, 32'h20, 0, 5'd4, 0);
    access("R7", 0, 2'd2, 0, 32'h10, 0, 5'd4, 1);
    access("R6", 0, 2'd1, 1, 32'h12, 0, 5'd4, 0);
    access("R7", 0, 2'd1, 1, 32'h12, 0, 5'd4, 1);

    // R5 byte invariance across modes
    access("R5", 1, 2'd0, 0, 32'h41, 32'h0000_005A, 5'd1, 1);
    access("R5", 0, 2'd0, 1, 32'h41, 0, 5'd5, 0);
    access("R5", 1, 2'd0, 0, 32'h43, 32'h0000_0077, 5'd1, 0);
    access("R5", 0, 2'd0, 1, 32'h43, 0, 5'd5, 1);

    // R8 extension
    access("R8", 1, 2'd0, 0, 32'h50, 32'h0000_0080, 5'd1, 0);
    access("R8", 0, 2'd0, 0, 32'h50, 0, 5'd6, 0);
    access("R8", 0, 2'd0, 1, 32'h50, 0, 5'd6, 0);
    access("R8", 1, 2'd1, 0, 32'h52, 32'h0000_8001, 5'd1, 1);
    access("R8", 0, 2'd1, 0, 32'h52, 0, 5'd6, 1);
    access("R8", 0, 2'd1, 1, 32'h52, 0, 5'd6, 1);
    access("R8", 0, 2'd1, 0, 32'h52, 0, 5'd6, 0);

    // R1 misaligned, nothing issued, no write
    g0 = grants;
    access("R1", 0, 2'd1, 0, 32'h11, 0, 5'd7, 0);
    access("R1", 0, 2'd2, 0, 32'h12, 0, 5'd7, 0);
    access("R1", 0, 2'd3, 0, 32'h10, 0, 5'd7, 0);
    access("R1", 1, 2'd2, 0, 32'h62, 32'hFFFF_FFFF, 5'd7, 0);
    access("R1", 1, 2'd1, 0, 32'h4000_0001, 32'hFFFF, 5'd7, 0);
    check("R1", "grants", 32'(grants - g0), 32'd0);
    access("R1", 0, 2'd2, 0, 32'h60, 0, 5'd7, 0);

    // R2 region rules
    g0 = grants;
    access("R2", 1, 2'd2, 0, 32'h4000_0010, 32'h0BAD_F00D, 5'd8, 0);
    access("R2", 0, 2'd0, 0, 32'h8000_0004, 0, 5'd8, 0);
    access("R2", 1, 2'd1, 0, 32'h8000_0004, 32'h1234, 5'd8, 1);
    check("R2", "grants", 32'(grants - g0), 32'd0);
    access("R2", 0, 2'd2, 0, 32'h4000_0010, 0, 5'd8, 0);
    access("R2", 1, 2'd2, 0, 32'h8000_0070, 32'h0102_0304, 5'd8, 1);
    access("R2", 0, 2'd2, 0, 32'h8000_0070, 0, 5'd8, 1);

    // R9 destination zero
    g0 = grants;
    access("R9", 0, 2'd2, 0, 32'h10, 0, 5'd0, 0);
    check("R9", "grants", 32'(grants - g0), 32'd1);
    access("R9", 0, 2'd1, 0, 32'h13, 0, 5'd0, 0);
    check("R9", "grants after fault", 32'(grants - g0), 32'd1);

    // R10 stalled memory
    stall = 3;
    access("R10", 1, 2'd2, 0, 32'h80, 32'hCAFE_F00D, 5'd9, 0);
    access("R10", 0, 2'd2, 0, 32'h80, 0, 5'd9, 1);
    stall = 1;
    access("R10", 0, 2'd1, 0, 32'h82, 0, 5'd9, 0);

    // R11 mode change during a stalled access
    stall = 2;
    access("R11", 1, 2'd2, 0, 32'h90, 32'h8899_AABB, 5'd10, 1, 1'b1);
    access("R11", 0, 2'd2, 0, 32'h90, 0, 5'd10, 0, 1'b1);
    stall = 0;
    access("R11", 0, 2'd0, 1, 32'h90, 0, 5'd10, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule